// File: doc/BRIEF.md
# Mid-Bit Aligned Oversampling Serial Receiver

This block receives asynchronous serial frames of one start bit, eight data bits (least significant first) and one stop bit. A one-cycle enable `os_tick_i` arrives at sixteen times the bit rate. The line is resynchronised and then sampled on each tick. A high-to-low transition on the line starts a tick counter. The counter places a sampling strobe at the centre of every bit of the frame.

Each strobe shifts the sampled bit into a serial-to-parallel register. On the tenth strobe, the complete frame goes straight into a holding register, which keeps it on the outputs. The receiver is idle again in that same cycle, so a start bit that follows the stop bit with no gap is still caught. A one-cycle valid pulse marks each update of the holding register. A window output is high while a frame is being received, and a framing-error flag records a stop bit sampled low. A synchronous clear input empties the holding register.

Top module: `uart_os_rx`

## Requirements
- R1: After reset `data_o`, `frame_o`, `frame_err_o`, `valid_o`, `win_o` and `strobe_o` are all 0.
- R2: A frame starts only when the synchronised line, sampled on ticks, goes from 1 to 0. A line that stays low after a frame does not start a new one.
- R3: Every accepted frame produces exactly 10 strobes. The first strobe comes 8 ticks after start detection and each following one comes 16 ticks later. Each strobe is one clock long and coincides with a tick.
- R4: If the line is 1 at the first strobe, the frame is dropped. `win_o` returns to 0, and there is no valid pulse and no change on the outputs.
- R5: `frame_o` bit 0 is the start bit, bit 9 is the stop bit and bits 8..1 are the data byte with the first received data bit in bit 1. `data_o` equals `frame_o[8:1]`.
- R6: The holding register loads on the tenth strobe. `valid_o` is high for exactly one clock in the cycle after that strobe, in which `win_o` is already 0. Frames sent back to back with no idle time are all received.
- R7: `win_o` is high for exactly 152 tick periods (8 + 9 x 16) per accepted frame.
- R8: When the stop bit is sampled as 0, the holding register is still loaded and `frame_err_o` becomes 1. A good stop bit sets it to 0.
- R9: `clr_hold_i` sets `data_o`, `frame_o` and `frame_err_o` to 0 on the next clock, and no valid pulse appears in that cycle.
- R10: Between valid pulses and clears, the held outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | Oversampling enable, one clock wide, 16 per bit |
| rx_i | input | 1 | Serial line, idle high |
| clr_hold_i | input | 1 | Synchronous clear of the held frame |
| data_o | output | 8 | Held data byte |
| frame_o | output | 10 | Held raw frame including start and stop |
| frame_err_o | output | 1 | Stop bit of the held frame was 0 |
| valid_o | output | 1 | One-clock pulse on each holding-register load |
| win_o | output | 1 | High while a frame is being received |
| strobe_o | output | 1 | Mid-bit sampling strobe |

## Verification
The assertions assume that `os_tick_i` is a one-clock pulse separated by idle cycles, that the serial line holds each bit for a whole number of tick periods, and that `clr_hold_i` never falls in the cycle of a valid pulse. The bench drives a tick every fourth clock. It changes the line only on bit boundaries of 64 clocks, except in the deliberate short glitch, and it pulses the clear only while the line is idle. Random bytes with random gaps of zero to two bit times are mixed with directed cases: a glitch, a bad stop bit with the line then held low, and a clear.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RECV = 1'b1
  } rx_state_e;
endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  // reset to the idle line level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_os_rx_timing.sv
module uart_os_rx_timing
  import uart_os_rx_pkg::*;
#(
  parameter int OS_RATE    = 16,
  parameter int FRAME_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_s_i,
  output logic win_o,
  output logic strobe_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             prev_q;
  logic             fall;
  logic             at_mid;

  assign fall     = tick_i && prev_q && !rx_s_i;
  assign at_mid   = (state_q == ST_RECV) && tick_i && (cnt_q == MID);
  assign strobe_o = at_mid;
  assign last_o   = at_mid && (idx_q == LAST);
  assign win_o    = (state_q == ST_RECV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else if (tick_i) prev_q <= rx_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fall) begin
            state_q <= ST_RECV;
            cnt_q   <= '0;
            idx_q   <= '0;
          end
        end
        ST_RECV: begin
          if (tick_i) cnt_q <= cnt_q + 1'b1;
          if (at_mid) begin
            // start bit high at its centre: treat as glitch
            if ((idx_q == '0) && rx_s_i) state_q <= ST_IDLE;
            else if (idx_q == LAST)      state_q <= ST_IDLE;
            else                          idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);                                                   // R3
  AST_START_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_o) |-> $past(tick_i) && !$past(rx_s_i));                // R2
  AST_STROBE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> tick_i && win_o);                                    // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);                                          // R3
endmodule

// File: rtl/uart_os_rx_hold.sv
module uart_os_rx_hold #(
  parameter int FRAME_BITS = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  strobe_i,
  input  logic                  last_i,
  input  logic                  bit_i,
  input  logic                  clr_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  err_o,
  output logic                  valid_o
);
  logic [FRAME_BITS-1:0] shift_q;
  logic [FRAME_BITS-1:0] capt;

  // full frame formed from the current sample, so handoff happens on the last strobe
  assign capt = {bit_i, shift_q[FRAME_BITS-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shift_q <= '0;
    else if (strobe_i) shift_q <= capt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      err_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (clr_i) begin
      frame_o <= '0;
      err_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (last_i) begin
      frame_o <= capt;
      err_o   <= !bit_i;
      valid_o <= 1'b1;
    end else begin
      valid_o <= 1'b0;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);                                            // R6
  AST_ERR_MATCH_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (err_o == !frame_o[FRAME_BITS-1]));                   // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (frame_o == '0) && !err_o && !valid_o);                 // R9
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !$past(clr_i)) |-> $stable(frame_o) && $stable(err_o)); // R10
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OS_RATE   = 16,
  parameter int DATA_BITS = 8,
  parameter int SYNC_FF   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   os_tick_i,
  input  logic                   rx_i,
  input  logic                   clr_hold_i,
  output logic [DATA_BITS-1:0]   data_o,
  output logic [DATA_BITS+1:0]   frame_o,
  output logic                   frame_err_o,
  output logic                   valid_o,
  output logic                   win_o,
  output logic                   strobe_o
);
  localparam int FRAME_BITS = DATA_BITS + 2;

  logic rx_s;
  logic last;

  uart_os_rx_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_os_rx_timing #(.OS_RATE(OS_RATE), .FRAME_BITS(FRAME_BITS)) u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (os_tick_i),
    .rx_s_i  (rx_s),
    .win_o   (win_o),
    .strobe_o(strobe_o),
    .last_o  (last)
  );

  uart_os_rx_hold #(.FRAME_BITS(FRAME_BITS)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_o),
    .last_i  (last),
    .bit_i   (rx_s),
    .clr_i   (clr_hold_i),
    .frame_o (frame_o),
    .err_o   (frame_err_o),
    .valid_o (valid_o)
  );

  assign data_o = frame_o[FRAME_BITS-2:1];

  AST_VALID_CLOSES_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !win_o);                                              // R6
  AST_DATA_MATCH_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !frame_o[0]);                                         // R5
endmodule

// File: tb/uart_os_rx_tb.sv
module uart_os_rx_tb;
  localparam int DIV      = 4;
  localparam int OS       = 16;
  localparam int BIT_CLK  = DIV * OS;
  localparam int WIN_CLK  = (OS / 2 + 9 * OS) * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic       clr = 1'b0;
  logic [7:0] data_o;
  logic [9:0] frame_o;
  logic       err_o, valid_o, win_o, strobe_o;

  int n_chk = 0, n_fail = 0;
  int valid_cnt = 0, win_clks = 0, strobe_cnt = 0, pulse_bad = 0;
  logic       prev_valid = 1'b0;
  logic [9:0] cap_frame = '0;
  logic       cap_err = 1'b0;
  int         tick_div = 0;

  always #2.5 clk = ~clk;

  uart_os_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(tick), .rx_i(rx), .clr_hold_i(clr),
    .data_o(data_o), .frame_o(frame_o), .frame_err_o(err_o), .valid_o(valid_o),
    .win_o(win_o), .strobe_o(strobe_o)
  );

  always @(negedge clk) begin
    tick_div = (tick_div + 1) % DIV;
    tick <= (tick_div == 0);
  end

  always @(negedge clk) begin
    if (valid_o) begin
      valid_cnt++;
      cap_frame = frame_o;
      cap_err   = err_o;
      if (prev_valid) pulse_bad++;
    end
    prev_valid = valid_o;
    if (win_o) win_clks++;
    if (strobe_o) strobe_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int clks);
    rx = v;
    repeat (clks) @(negedge clk);
  endtask

  function automatic logic [9:0] exp_frame(input logic [7:0] b, input logic stop);
    return {stop, b, 1'b0};
  endfunction

  task automatic send(input logic [7:0] b, input logic stop);
    int v0;
    logic [9:0] f;
    f = exp_frame(b, stop);
    v0 = valid_cnt;
    win_clks = 0;
    strobe_cnt = 0;
    for (int i = 0; i < 10; i++) hold_line(f[i], BIT_CLK);
    chk(valid_cnt == v0 + 1, "R6 one load per frame", valid_cnt - v0, 1);
    chk(cap_frame == f, "R5 frame layout", cap_frame, f);
    chk(data_o == b, "R5 data byte", data_o, b);
    chk(cap_err == !stop, "R8 framing flag", cap_err, !stop);
    chk(strobe_cnt == 10, "R3 strobes per frame", strobe_cnt, 10);
    chk(win_clks == WIN_CLK, "R7 window length", win_clks, WIN_CLK);
  endtask

  initial begin
    #(150000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    int v0;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk({data_o, frame_o, err_o, valid_o, win_o, strobe_o} == '0, "R1 reset state",
        {data_o, frame_o, err_o, valid_o, win_o, strobe_o}, 0);
    rst_n = 1'b1;
    hold_line(1'b1, 2 * BIT_CLK);
    chk(win_o == 1'b0, "R1 idle window", win_o, 0);

    // directed patterns
    send(8'h00, 1'b1);
    send(8'hFF, 1'b1);
    send(8'hA5, 1'b1);
    send(8'h3C, 1'b1);  // back to back with the previous frame
    hold_line(1'b1, BIT_CLK);

    // R10: held value stays while idle
    keep = data_o;
    hold_line(1'b1, 3 * BIT_CLK);
    chk(data_o == keep, "R10 hold stable", data_o, keep);

    // R4: short low pulse is rejected
    v0 = valid_cnt;
    hold_line(1'b0, 3 * DIV);
    hold_line(1'b1, 3 * BIT_CLK);
    chk(valid_cnt == v0, "R4 glitch no load", valid_cnt - v0, 0);
    chk(win_o == 1'b0, "R4 window closed", win_o, 0);
    chk(data_o == keep, "R4 data unchanged", data_o, keep);

    // R8 and R2: bad stop bit, then line left low
    send(8'h96, 1'b0);
    v0 = valid_cnt;
    hold_line(1'b0, 2 * BIT_CLK);
    chk(win_o == 1'b0, "R2 low line no start", win_o, 0);
    hold_line(1'b1, 2 * BIT_CLK);
    chk(valid_cnt == v0, "R2 no spurious frame", valid_cnt - v0, 0);
    chk(err_o == 1'b1, "R8 flag held", err_o, 1);

    send(8'h5A, 1'b1);
    hold_line(1'b1, BIT_CLK);
    chk(err_o == 1'b0, "R8 flag cleared by good stop", err_o, 0);

    // R9: clear
    v0 = valid_cnt;
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk({data_o, frame_o, err_o} == '0, "R9 clear", {data_o, frame_o, err_o}, 0);
    chk(valid_cnt == v0, "R9 no valid on clear", valid_cnt - v0, 0);

    // random bytes, random gaps including none
    for (int k = 0; k < 24; k++) begin
      send(8'($urandom), 1'b1);
      hold_line(1'b1, int'($urandom % 3) * BIT_CLK);
    end
    hold_line(1'b1, BIT_CLK);
    chk(pulse_bad == 0, "R6 valid one clock", pulse_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule